// File: doc/BRIEF.md
# Tic-Tac-Toe Game Sequencer

This block referees a full game of tic-tac-toe between two external move sources, one placing X marks and one placing O marks. It keeps the board as two nine-bit occupancy registers and shows them on its outputs. It tells each side when its turn has come. It takes that side's one-hot move on a clock edge when the side raises its valid strobe, and it checks the move before merging it into the board. Choosing a move is left to the players. The sequencer only enforces turn order, legality and the end of the game.

A start pulse clears the board and the result flags. It also samples a first-mover select to decide whether X or O opens. After each accepted move the sequencer checks the mover's marks for a completed line of three before it looks for a full board. The game then ends in a win for X, a win for O, a draw, or an illegal-move stop. The end state holds until the next start.

Top module: `ttt_game_seq`

## Requirements
- R1: While reset is applied, and after it until the first start, both board vectors read zero and `x_turn`, `o_turn`, `x_wins`, `o_wins`, `draw`, `illegal` and `game_over` are all low.
- R2: A `start` pulse clears both board vectors and all result flags on that clock edge. It then grants the turn to O when `o_first` is 1 and to X when `o_first` is 0, and it takes precedence over any move presented in the same cycle.
- R3: A move is sampled only from the player whose turn output is high. A strobe or move from the other player, or from either player while no game is running, leaves the board, the turn and the flags unchanged.
- R4: An accepted move is ORed into the mover's own occupancy vector (bit k is square k, numbered row by row from bit 0 at top-left to bit 8 at bottom-right). The turn then passes to the other player on the same edge.
- R5: A move with zero or with more than one bit set raises `illegal` and ends the game, and neither board vector changes.
- R6: A one-hot move whose bit is already set in either occupancy vector raises `illegal` and ends the game without changing the board.
- R7: When an accepted move completes a line for the mover (rows {0,1,2}, {3,4,5}, {6,7,8}; columns {0,3,6}, {1,4,7}, {2,5,8}; diagonals {0,4,8} and {2,4,6}), that mover's win flag (`x_wins` or `o_wins`) rises and the game ends.
- R8: A move that fills the ninth square and also completes a line reports a win and not a draw.
- R9: A move that fills the ninth square without completing a line for the mover raises `draw` and ends the game.
- R10: Once the game has ended, the board and all result flags hold their values and every move is ignored until the next `start`.
- R11: `game_over` is high exactly when one of the four result flags is high. At most one of `x_turn`, `o_turn` and `game_over` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Clears the board and begins a new game |
| o_first | input | 1 | Sampled with `start`: 1 lets O open, 0 lets X open |
| x_valid | input | 1 | X player presents a move |
| x_move | input | 9 | X player's move, one-hot square select |
| o_valid | input | 1 | O player presents a move |
| o_move | input | 9 | O player's move, one-hot square select |
| board_x | output | 9 | Squares held by X |
| board_o | output | 9 | Squares held by O |
| x_turn | output | 1 | Waiting for X |
| o_turn | output | 1 | Waiting for O |
| x_wins | output | 1 | X completed a line |
| o_wins | output | 1 | O completed a line |
| draw | output | 1 | Board full with no line |
| illegal | output | 1 | Last presented move was rejected |
| game_over | output | 1 | Game has ended |

## Verification
The hardest case to reach is the ninth move. To get there, the stimulus has to drive eight accepted moves that leave no finished line on the board. Only then can it show that a line completed on the last square reports a win and not a draw. The bench feeds scripted games whose square orders were chosen so that no line is completed before the final move. One game ends in a plain draw and one ends in a column completed on the ninth square. A behavioural model in the bench, updated every edge, follows the board and the flags through these games and through rejected moves, strobes from the wrong player, and moves sent after the end of a game.

// File: rtl/ttt_pkg.sv
package ttt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XWAIT = 2'd1,
    ST_OWAIT = 2'd2,
    ST_OVER  = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic x_win;
    logic o_win;
    logic tie;
    logic bad;
  } result_t;

endpackage

// File: rtl/ttt_move_check.sv
module ttt_move_check #(
  parameter int NSQ = 9
) (
  input  logic [NSQ-1:0] move,
  input  logic [NSQ-1:0] occ_mine,
  input  logic [NSQ-1:0] occ_other,
  output logic           one_hot,
  output logic           clash,
  output logic           legal
);
  logic [NSQ-1:0] lower;

  // move & (move - 1) clears the lowest set bit; zero left means at most one bit
  assign lower   = move - NSQ'(1);
  assign one_hot = (move != '0) && ((move & lower) == '0);
  assign clash   = ((move & (occ_mine | occ_other)) != '0);
  assign legal   = one_hot && !clash;
endmodule

// File: rtl/ttt_line_detect.sv
module ttt_line_detect #(
  parameter int SIDE = 3,
  parameter int NSQ  = SIDE * SIDE
) (
  input  logic [NSQ-1:0] marks,
  output logic           line_hit
);
  localparam int NLINE = 2 * SIDE + 2;

  logic [NLINE-1:0] hit;

  function automatic logic [NSQ-1:0] row_mask(input int r);
    logic [NSQ-1:0] m;
    m = '0;
    for (int c = 0; c < SIDE; c++) m[r * SIDE + c] = 1'b1;
    return m;
  endfunction

  function automatic logic [NSQ-1:0] col_mask(input int c);
    logic [NSQ-1:0] m;
    m = '0;
    for (int r = 0; r < SIDE; r++) m[r * SIDE + c] = 1'b1;
    return m;
  endfunction

  function automatic logic [NSQ-1:0] diag_mask(input bit anti);
    logic [NSQ-1:0] m;
    m = '0;
    for (int i = 0; i < SIDE; i++)
      m[i * SIDE + (anti ? (SIDE - 1 - i) : i)] = 1'b1;
    return m;
  endfunction

  for (genvar g = 0; g < SIDE; g++) begin : g_rc
    localparam logic [NSQ-1:0] RMASK = row_mask(g);
    localparam logic [NSQ-1:0] CMASK = col_mask(g);
    assign hit[g]        = ((marks & RMASK) == RMASK);
    assign hit[SIDE + g] = ((marks & CMASK) == CMASK);
  end

  localparam logic [NSQ-1:0] DMASK = diag_mask(1'b0);
  localparam logic [NSQ-1:0] AMASK = diag_mask(1'b1);
  assign hit[2 * SIDE]     = ((marks & DMASK) == DMASK);
  assign hit[2 * SIDE + 1] = ((marks & AMASK) == AMASK);

  assign line_hit = |hit;
endmodule

// File: rtl/ttt_game_seq.sv
module ttt_game_seq
  import ttt_pkg::*;
#(
  parameter  int SIDE        = 3,
  parameter  int SYNC_STAGES = 2,
  localparam int NSQ         = SIDE * SIDE
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           o_first,
  input  logic           x_valid,
  input  logic [NSQ-1:0] x_move,
  input  logic           o_valid,
  input  logic [NSQ-1:0] o_move,
  output logic [NSQ-1:0] board_x,
  output logic [NSQ-1:0] board_o,
  output logic           x_turn,
  output logic           o_turn,
  output logic           x_wins,
  output logic           o_wins,
  output logic           draw,
  output logic           illegal,
  output logic           game_over
);

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  // state registers
  seq_state_t     state_q, state_n;
  logic [NSQ-1:0] bx_q, bx_n, bo_q, bo_n;
  result_t        res_q, res_n;
  logic           load;

  // mover selection
  logic           o_moving;
  logic           mv_valid;
  logic [NSQ-1:0] mv;
  logic [NSQ-1:0] occ_mine, occ_other, mine_n;
  logic           mv_one_hot, mv_clash, mv_legal, mine_line, board_full;

  assign o_moving  = (state_q == ST_OWAIT);
  assign mv_valid  = ((state_q == ST_XWAIT) && x_valid) ||
                     ((state_q == ST_OWAIT) && o_valid);
  assign mv        = o_moving ? o_move : x_move;
  assign occ_mine  = o_moving ? bo_q : bx_q;
  assign occ_other = o_moving ? bx_q : bo_q;
  assign mine_n    = occ_mine | mv;
  assign board_full = &(mine_n | occ_other);

  ttt_move_check #(.NSQ(NSQ)) u_check (
    .move      (mv),
    .occ_mine  (occ_mine),
    .occ_other (occ_other),
    .one_hot   (mv_one_hot),
    .clash     (mv_clash),
    .legal     (mv_legal)
  );

  ttt_line_detect #(.SIDE(SIDE), .NSQ(NSQ)) u_lines (
    .marks    (mine_n),
    .line_hit (mine_line)
  );

  // next-state logic
  always_comb begin
    state_n = state_q;
    bx_n    = bx_q;
    bo_n    = bo_q;
    res_n   = res_q;
    load    = 1'b0;
    if (start) begin
      load    = 1'b1;
      bx_n    = '0;
      bo_n    = '0;
      res_n   = '0;
      state_n = o_first ? ST_OWAIT : ST_XWAIT;
    end else if (mv_valid) begin
      load = 1'b1;
      if (!mv_legal) begin
        res_n.bad = 1'b1;
        state_n   = ST_OVER;
      end else begin
        if (o_moving) bo_n = mine_n;
        else          bx_n = mine_n;
        if (mine_line) begin
          if (o_moving) res_n.o_win = 1'b1;
          else          res_n.x_win = 1'b1;
          state_n = ST_OVER;
        end else if (board_full) begin
          res_n.tie = 1'b1;
          state_n   = ST_OVER;
        end else begin
          state_n = o_moving ? ST_XWAIT : ST_OWAIT;
        end
      end
    end
  end

  // registers with explicit enable
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      bx_q    <= '0;
      bo_q    <= '0;
      res_q   <= '0;
    end else if (load) begin
      state_q <= state_n;
      bx_q    <= bx_n;
      bo_q    <= bo_n;
      res_q   <= res_n;
    end
  end

  assign board_x   = bx_q;
  assign board_o   = bo_q;
  assign x_turn    = (state_q == ST_XWAIT);
  assign o_turn    = (state_q == ST_OWAIT);
  assign x_wins    = res_q.x_win;
  assign o_wins    = res_q.o_win;
  assign draw      = res_q.tie;
  assign illegal   = res_q.bad;
  assign game_over = (state_q == ST_OVER);

endmodule

// File: rtl/ttt_game_seq_chk.sv
module ttt_game_seq_chk #(
  parameter int NSQ = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           x_valid,
  input logic           o_valid,
  input logic [NSQ-1:0] board_x,
  input logic [NSQ-1:0] board_o,
  input logic           x_turn,
  input logic           o_turn,
  input logic           x_wins,
  input logic           o_wins,
  input logic           draw,
  input logic           illegal,
  input logic           game_over
);

  p_one_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({x_turn, o_turn, game_over}));

  p_over_matches_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    game_over == (x_wins | o_wins | draw | illegal));

  p_single_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({x_wins, o_wins, draw, illegal}));

  p_disjoint_board_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (board_x & board_o) == '0);

  p_one_square_per_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($countones(board_x ^ $past(board_x)) +
                $countones(board_o ^ $past(board_o))) <= 1);

  p_board_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((board_x & $past(board_x)) == $past(board_x)) &&
               ((board_o & $past(board_o)) == $past(board_o)));

  p_over_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    game_over && !start |=> game_over && $stable(board_x) && $stable(board_o));

  p_x_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    x_turn && !x_valid && !start |=> x_turn && $stable(board_o));

  p_o_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    o_turn && !o_valid && !start |=> o_turn && $stable(board_x));

  p_draw_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    draw |-> &(board_x | board_o));

endmodule

bind ttt_game_seq ttt_game_seq_chk #(.NSQ(NSQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .x_valid   (x_valid),
  .o_valid   (o_valid),
  .board_x   (board_x),
  .board_o   (board_o),
  .x_turn    (x_turn),
  .o_turn    (o_turn),
  .x_wins    (x_wins),
  .o_wins    (o_wins),
  .draw      (draw),
  .illegal   (illegal),
  .game_over (game_over)
);

// File: tb/ttt_game_seq_tb_top.sv
module ttt_game_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, o_first, x_valid, o_valid;
  logic [8:0] x_move, o_move;
  logic [8:0] board_x, board_o;
  logic       x_turn, o_turn, x_wins, o_wins, draw, illegal, game_over;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  bit cmp_en = 0;

  always #10 clk = ~clk;

  ttt_game_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .o_first(o_first),
    .x_valid(x_valid), .x_move(x_move), .o_valid(o_valid), .o_move(o_move),
    .board_x(board_x), .board_o(board_o), .x_turn(x_turn), .o_turn(o_turn),
    .x_wins(x_wins), .o_wins(o_wins), .draw(draw), .illegal(illegal),
    .game_over(game_over)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [8:0] mx, mo;
  int       mphase;      // 0 idle, 1 X to move, 2 O to move, 3 finished
  bit       mxw, mow, mdr, mil;
  int       msync;

  function automatic bit has_three(bit [8:0] b);
    for (int l = 0; l < 8; l++) begin
      int a, s;
      if (l < 3)       begin a = 3 * l; s = 1; end
      else if (l < 6)  begin a = l - 3; s = 3; end
      else if (l == 6) begin a = 0;     s = 4; end
      else             begin a = 2;     s = 2; end
      if (b[a] && b[a + s] && b[a + 2 * s]) return 1'b1;
    end
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mx = '0; mo = '0; mphase = 0; mxw = 0; mow = 0; mdr = 0; mil = 0; msync = 0;
    end else if (msync < 2) begin
      msync++;
    end else if (start) begin
      mx = '0; mo = '0; mxw = 0; mow = 0; mdr = 0; mil = 0;
      mphase = o_first ? 2 : 1;
    end else if ((mphase == 1 && x_valid) || (mphase == 2 && o_valid)) begin
      bit [8:0] m;
      bit [8:0] own;
      m = (mphase == 1) ? x_move : o_move;
      if ($countones(m) != 1 || (m & (mx | mo)) != 0) begin
        mil = 1; mphase = 3;
      end else begin
        if (mphase == 1) mx = mx | m; else mo = mo | m;
        own = (mphase == 1) ? mx : mo;
        if (has_three(own)) begin
          if (mphase == 1) mxw = 1; else mow = 1;
          mphase = 3;
        end else if ((mx | mo) == 9'h1FF) begin
          mdr = 1; mphase = 3;
        end else begin
          mphase = (mphase == 1) ? 2 : 1;
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check("R4 board_x", board_x, mx);
      check("R4 board_o", board_o, mo);
      check("R2 x_turn", x_turn, mphase == 1);
      check("R2 o_turn", o_turn, mphase == 2);
      check("R7 x_wins", x_wins, mxw);
      check("R7 o_wins", o_wins, mow);
      check("R9 draw", draw, mdr);
      check("R5 illegal", illegal, mil);
      check("R11 game_over", game_over, mphase == 3);
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_start(input bit of);
    start = 1; o_first = of;
    @(negedge clk);
    start = 0;
  endtask

  task automatic put(input bit is_o, input logic [8:0] m);
    if (is_o) begin o_valid = 1; o_move = m; end
    else      begin x_valid = 1; x_move = m; end
    @(negedge clk);
    x_valid = 0; o_valid = 0; x_move = '0; o_move = '0;
  endtask

  task automatic play(input bit of, input int sq[$]);
    bit who;
    do_start(of);
    who = of;
    foreach (sq[i]) begin
      put(who, 9'(1) << sq[i]);
      who = !who;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; start = 0; o_first = 0; x_valid = 0; o_valid = 0;
    x_move = '0; o_move = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 board_x", board_x, 0);
    check("R1 board_o", board_o, 0);
    check("R1 flags", {x_turn, o_turn, x_wins, o_wins, draw, illegal, game_over}, 0);
    rst_n = 1;
    cmp_en = 1;
    repeat (3) @(negedge clk);
    // R3: moves before any start are ignored
    put(1'b0, 9'h010);
    check("R3 idle move", board_x, 0);

    // X opens, wrong-player strobe, then top-row win
    do_start(1'b0);
    check("R2 x first", x_turn, 1);
    put(1'b1, 9'h001);
    check("R3 o ignored", board_o, 0);
    check("R3 still x", x_turn, 1);
    play(1'b0, '{0, 3, 1, 4, 2});
    check("R7 row win", x_wins, 1);
    // R10: moves after the end are ignored
    put(1'b0, 9'h100);
    put(1'b1, 9'h100);
    check("R10 board held", board_x | board_o, 9'h01F);
    check("R10 over held", game_over, 1);

    // O opens and wins on the anti-diagonal
    play(1'b1, '{2, 0, 4, 1, 6});
    check("R7 anti diag", o_wins, 1);
    check("R2 o first seen", x_wins, 0);

    // X wins on main diagonal
    play(1'b0, '{0, 1, 4, 2, 8});
    check("R7 main diag", x_wins, 1);

    // O wins a column
    play(1'b1, '{1, 0, 4, 2, 7});
    check("R7 column", o_wins, 1);

    // R5: two-bit move
    play(1'b0, '{4});
    put(1'b1, 9'h003);
    check("R5 multi bit", illegal, 1);
    check("R5 board kept", board_o, 0);
    // R5: zero move
    do_start(1'b0);
    put(1'b0, 9'h000);
    check("R5 zero move", illegal, 1);

    // R6: occupied by the other side
    play(1'b0, '{4});
    put(1'b1, 9'h010);
    check("R6 clash other", illegal, 1);
    check("R6 board kept", board_o, 0);
    // R6: occupied by the mover itself
    play(1'b0, '{4, 0});
    put(1'b0, 9'h010);
    check("R6 clash own", illegal, 1);

    // R9: full board, no line
    play(1'b0, '{4, 0, 2, 6, 3, 5, 7, 1, 8});
    check("R9 draw", draw, 1);
    check("R9 no win", x_wins | o_wins, 0);

    // R8: ninth square completes a column
    play(1'b0, '{0, 1, 2, 4, 3, 5, 7, 8, 6});
    check("R8 win over draw", x_wins, 1);
    check("R8 not draw", draw, 0);

    // R2: start in mid game restarts, and beats a same-cycle move
    play(1'b1, '{4, 0});
    start = 1; o_first = 0; x_valid = 1; x_move = 9'h002;
    @(negedge clk);
    start = 0; x_valid = 0; x_move = '0;
    check("R2 restart clears", board_x | board_o, 0);
    check("R2 restart turn", x_turn, 1);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule